// File: doc/BRIEF.md
# Signed successive-approximation search engine

This block is the digital half of a sign-and-magnitude successive-approximation converter. A one-clock start pulse begins a conversion. The engine first spends one clock deciding the polarity of the held input against ground. It then runs a binary search over a 12-bit magnitude, most significant bit first. Each step takes one clock and one comparator decision. The block drives the level under test to an external DAC model as a signed 13-bit trial code. When the last magnitude bit is settled, the block latches a 13-bit two's-complement result and raises a done flag for one clock.

For a negative input the search runs on the distance below minus one LSB. In that case the trial level is `-1 - m` rather than `-m`, and the result is the bitwise inverse of the magnitude with the sign bit set. This gives 4095 positive codes, zero, and 4096 negative codes, with no extra correction logic. An input beyond either end pins the result to +4095 or -4096. A start pulse that arrives during a conversion abandons that conversion and begins a new one from the polarity step.

Top module: `signfirst_sar`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, and `result` and `trialCode` are all zeros until the first conversion.
- R2: In the clock after a start pulse is sampled, `trialCode` is zero, meaning the input is compared with ground. A comparator value of 1 in that clock sets the sign to 0 (input at or above ground). A value of 0 sets the sign to 1.
- R3: The trial code is a two's-complement level with the sign in bit 12. With sign 0 the level is the trial magnitude `m`. With sign 1 the level is `-1 - m`. The first magnitude trial has only magnitude bit 11 set, and every bit below the bit under test is 0.
- R4: Bits are tested from bit 11 down to bit 0, one per clock. A comparator value of 1 in a bit's clock keeps that bit, and 0 clears it. The next clock then tests the next lower bit.
- R5: `done` is high for exactly one clock. It rises on the 14th rising edge counting the edge that samples the start pulse as the first, which is 13 clocks after the start.
- R6: `result` changes only on the edge that raises `done` and holds its value until the next one. With sign 0 it is `{0, m}`, and with sign 1 it is `{1, ~m}`. With a comparator that answers "input at or beyond the trial level, away from zero", the result equals the integer input clamped to the range -4096..+4095.
- R7: A start pulse during a conversion discards the partial bits and restarts at the polarity step. `done` then follows R5, counted from the new pulse.
- R8: While no conversion is running, the comparator input has no effect: `done` stays 0 and `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | One-clock request to begin (or restart) a conversion |
| cmpHigh | input | 1 | Comparator decision for the current trial |
| trialCode | output | 13 | Signed level presented to the DAC |
| done | output | 1 | One-clock pulse when a result is latched |
| result | output | 13 | Two's-complement conversion result |

## Verification
On every clock, assertions check the following:
- `trialCode` is zero during the polarity step.
- The sign bit of the trial stays steady through a search.
- No bit below the bit under test is set.
- `done` never lasts two clocks, and it arrives exactly 13 clocks after the latest start.
- `result` moves only together with `done`.

Only the bench scenarios can show that the latched codes are correct. The bench sweeps integer inputs across and beyond the full range, including both ends and the values around zero. It also checks the exact step-by-step trial sequence, a restart in the middle of a conversion, and comparator activity while the engine is idle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic clearAll;
    logic takeSign;
    logic takeBit;
    logic latchOut;
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startPulse,
  output sarStrobe_t               strb,
  output logic [$clog2(MAG_W)-1:0] bitIdx,
  output logic                     done
);
  localparam int CW = $clog2(MAG_W + 1);
  localparam int IW = $clog2(MAG_W);
  localparam logic [CW-1:0] LAST = CW'(MAG_W);

  logic          busy;
  logic [CW-1:0] stepCnt;
  logic [CW-1:0] remain;

  always_comb begin
    remain        = LAST - stepCnt;
    bitIdx        = remain[IW-1:0];
    strb.clearAll = startPulse;
    strb.takeSign = busy && (stepCnt == '0) && !startPulse;
    strb.takeBit  = busy && (stepCnt != '0) && !startPulse;
    strb.latchOut = strb.takeBit && (stepCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.latchOut;
      if (startPulse) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (stepCnt == LAST) busy <= 1'b0;
        else stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sarStrobe_t               strb,
  input  logic [$clog2(MAG_W)-1:0] bitIdx,
  input  logic                     cmpHigh,
  output logic [MAG_W:0]           trialCode,
  output logic [MAG_W:0]           result
);
  localparam logic [MAG_W-1:0] ONE = MAG_W'(1);

  logic             signBit;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] bitMask;
  logic [MAG_W-1:0] trialMag;
  logic [MAG_W-1:0] nextMag;
  logic [MAG_W:0]   resReg;

  always_comb begin
    bitMask   = ONE << bitIdx;
    trialMag  = strb.takeBit ? (mag | bitMask) : mag;
    nextMag   = cmpHigh ? (mag | bitMask) : mag;
    trialCode = {signBit, signBit ? ~trialMag : trialMag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signBit <= 1'b0;
      mag     <= '0;
      resReg  <= '0;
    end else begin
      if (strb.clearAll) begin
        signBit <= 1'b0;
        mag     <= '0;
      end else if (strb.takeSign) begin
        signBit <= !cmpHigh;
      end else if (strb.takeBit) begin
        mag <= nextMag;
      end
      if (strb.latchOut && !strb.clearAll)
        resReg <= {signBit, signBit ? ~nextMag : nextMag};
    end
  end

  assign result = resReg;

  // R2
  sign_phase_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeSign |-> (trialCode == '0));
  // R3
  low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeBit |-> ((trialMag & (bitMask - ONE)) == '0));
  // R3
  sign_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeBit && $past(strb.takeBit)) |-> $stable(trialCode[MAG_W]));
endmodule

// File: rtl/signfirst_sar.sv
module signfirst_sar
  import sar_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startPulse,
  input  logic           cmpHigh,
  output logic [MAG_W:0] trialCode,
  output logic           done,
  output logic [MAG_W:0] result
);
  localparam int IW = $clog2(MAG_W);
  localparam int SW = $clog2(MAG_W + 1) + 2;

  sarStrobe_t    strb;
  logic [IW-1:0] bitIdx;

  sar_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .strb(strb), .bitIdx(bitIdx), .done(done)
  );

  sar_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .cmpHigh(cmpHigh), .trialCode(trialCode), .result(result)
  );

  // Window checker: clocks since the latest start pulse, saturating.
  logic [SW-1:0] sinceStart;
  always_ff @(posedge clk) begin
    if (!rstN) sinceStart <= '0;
    else if (startPulse) sinceStart <= SW'(1);
    else if (sinceStart != '1) sinceStart <= sinceStart + 1'b1;
  end

  // R5 R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStart == SW'(MAG_W + 2)));
  // R6 R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
endmodule

// File: tb/signfirst_sar_bench.sv
module signfirst_sar_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        cmpHigh;
  logic [12:0] trialCode;
  logic        done;
  logic [12:0] result;

  int target = 0;
  int cmpMode = 0;   // 0 model, 1 force 1, 2 force 0
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  signfirst_sar u_signfirst_sar (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .done(done), .result(result)
  );

  // Behavioural comparator: true when the input is at or beyond the level, away from zero.
  always_comb begin
    int lvl;
    lvl = int'($signed(trialCode));
    if (cmpMode == 1) cmpHigh = 1'b1;
    else if (cmpMode == 2) cmpHigh = 1'b0;
    else cmpHigh = trialCode[12] ? (target <= lvl) : (target >= lvl);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampVal(input int t);
    if (t > 4095) return 4095;
    if (t < -4096) return -4096;
    return t;
  endfunction

  // Full conversion with trace and timing checks; start driven on a falling edge.
  task automatic convert(input int t);
    bit earlyDone = 0;
    bit traceOk = 1;
    int badTrace = 0;
    int expTrace = 0;
    int dec = 0;
    bit neg;
    neg = (t < 0);
    target = t;
    startPulse = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 1) startPulse = 1'b0;
      if (k < 14 && done) earlyDone = 1;
      if (k == 1) begin
        if (trialCode != 13'd0) begin traceOk = 0; badTrace = int'($signed(trialCode)); expTrace = 0; end
      end else if (k <= 13) begin
        int trial, lvl;
        trial = dec | (1 << (13 - k));
        lvl = neg ? (-1 - trial) : trial;
        if (int'($signed(trialCode)) != lvl && traceOk) begin
          traceOk = 0; badTrace = int'($signed(trialCode)); expTrace = lvl;
        end
        if (neg ? (t <= lvl) : (t >= lvl)) dec = trial;
      end
    end
    check(traceOk, "R2/R3/R4 trial sequence", badTrace, expTrace);
    check(!earlyDone, "R5 no early done", int'(earlyDone), 0);
    check(done == 1'b1, "R5 done on 13th clock", int'(done), 1);
    check(int'($signed(result)) == clampVal(t), "R6 result", int'($signed(result)), clampVal(t));
    @(negedge clk);
    check(done == 1'b0, "R5 done one clock", int'(done), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(result == 13'd0, "R1 result in reset", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(trialCode == 13'd0, "R1 trial after reset", int'(trialCode), 0);
    check(result == 13'd0 && !done, "R1 idle after reset", int'(result), 0);

    // R6 boundaries and values around zero
    convert(0);      convert(1);     convert(-1);
    convert(4095);   convert(4096);  convert(-4096);
    convert(-4097);  convert(9000);  convert(-9000);
    convert(2048);   convert(-2048); convert(-2049);
    convert(1000);   convert(-1000);
    // R4 R6 sweep beyond the full range
    for (int t = -4200; t <= 4200; t += 7) convert(t);

    // R7 restart mid-conversion
    begin
      bit sawDone = 0;
      target = 3000;
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
      repeat (6) begin @(negedge clk); if (done) sawDone = 1; end
      check(!sawDone, "R7 no done before restart", int'(sawDone), 0);
      convert(-77);
      convert(1234);
    end

    // R8 comparator activity while idle
    begin
      logic [12:0] held;
      bit sawDone = 0;
      bit moved = 0;
      held = result;
      for (int i = 0; i < 40; i++) begin
        cmpMode = (i % 3 == 0) ? 1 : 2;
        target = (i % 2 == 0) ? 4000 : -4000;
        @(negedge clk);
        if (done) sawDone = 1;
        if (result != held) moved = 1;
      end
      cmpMode = 0;
      check(!sawDone, "R8 no done while idle", int'(sawDone), 0);
      check(!moved, "R8 result held while idle", int'(result), int'(held));
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule